// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block takes a floating-point value that has already been unpacked into a sign, a class code, an unbiased signed exponent and a normalized mantissa, and turns it into a signed two's-complement integer. The conversion always truncates toward zero. It ignores any rounding mode that may be configured elsewhere.

Two exception flags come with the result. The inexact flag reports that fraction bits were discarded. The invalid flag reports that the value cannot be represented. In that case the output saturates to the largest or smallest integer, chosen by the sign, and the inexact flag is forced low.

The logic is combinational, followed by one register stage. The register stage carries a valid bit beside the data. The mantissa carries its leading one in its top bit, so a value reads as 1.f × 2^exp. The mantissa must be wider than the integer result.

Top module: `fti_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_result`, `out_inexact` and `out_invalid` all become 0.
- R2: `out_valid` equals `in_valid` from the previous cycle. Results appear one cycle after the input. When `in_valid` is low, the result and flag outputs keep their previous values.
- R3: Class code 0 (zero) gives a result of 0 with both flags clear, whatever the sign, exponent and mantissa.
- R4: Class code 1 is a finite number. Codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and any unused code 5 to 7 are treated as overflow.
- R5: A number whose exponent is 32 or more overflows.
- R6: For a number with exponent 0 to 31, the result is the integer part of 1.f × 2^exp. The mantissa is `in_mant` with its top bit as the leading one. Bits below the binary point are discarded, which is truncation toward zero for either sign.
- R7: `out_inexact` is 1 exactly when a non-overflowing number had a nonzero bit discarded.
- R8: A number with a negative exponent, however large that exponent is in magnitude, gives 0 with `out_inexact` set.
- R9: An integer magnitude of 2^31 or more overflows when positive. For a negative value the limit is 2^31 + 1, so a magnitude of exactly 2^31 with sign 1 gives 0x80000000 without invalid.
- R10: On overflow, `out_invalid` is 1 and `out_inexact` is 0, even if bits were discarded. The result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R11: A non-overflowing result with sign 1 is the two's-complement negation of the magnitude.
- R12: `out_inexact` and `out_invalid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operand is present this cycle |
| in_sign | input | 1 | Sign of the operand, 1 = negative |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | EXP_W (16) | Unbiased exponent, signed |
| in_mant | input | MANT_W (64) | Normalized mantissa, leading one in the top bit |
| out_valid | output | 1 | Result is valid |
| out_result | output | INT_W (32) | Two's-complement integer result |
| out_inexact | output | 1 | Discarded fraction bits were nonzero |
| out_invalid | output | 1 | Value out of range or not a number |

## Verification
The assertions check the following on every cycle:
- the valid pipeline and the hold of the outputs;
- the mutual exclusion of the two flags;
- the fixed outputs for zero, special classes and large exponents;
- the zero-with-inexact result for negative exponents.

Only the bench's scenarios can show the rest, because that needs an arithmetic reference to compare against:
- the exact integer produced by the truncating shift;
- the asymmetric limit at 2^31;
- the negation of negative results;
- the inexact flag on the boundary vectors.

// File: rtl/fti_pkg.sv
// Package: shared class codes for the float-to-integer converter.
// Assumes the class field is three bits wide. Codes above 4 are unused.
package fti_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fti_class_e;

endpackage

// File: rtl/fti_shamt.sv
// Module: fti_shamt
// Turns the unbiased exponent into a right-shift distance for the mantissa.
// The distance is clamped to MANT_W, which shifts every bit out.
// It also flags exponents too large for the integer range.
// Assumes the mantissa's leading one sits at bit MANT_W-1.
module fti_shamt #(
    parameter int EXP_W  = 16,
    parameter int MANT_W = 64,
    parameter int INT_W  = 32,
    parameter int SH_W   = $clog2(MANT_W + 1)
) (
    input  logic signed [EXP_W-1:0] exp_i,
    output logic [SH_W-1:0]         shamt_o,
    output logic                    big_o
);

    localparam int DW = EXP_W + 2;
    localparam logic signed [DW-1:0] TOP_POS = DW'(MANT_W - 1);
    localparam logic signed [DW-1:0] SAT_SH  = DW'(MANT_W);
    localparam logic signed [DW-1:0] LIMIT   = DW'(INT_W);

    logic signed [DW-1:0] exp_ext;
    logic signed [DW-1:0] raw_sh;

    // Purpose: sign-extend the exponent and form top position minus exponent.
    always_comb begin
        exp_ext = DW'(exp_i);
        raw_sh  = TOP_POS - exp_ext;
    end

    // Purpose: clamp the distance to the range 0..MANT_W.
    always_comb begin
        if (raw_sh > SAT_SH) begin
            shamt_o = SH_W'(MANT_W);
        end else if (raw_sh < 0) begin
            shamt_o = '0;
        end else begin
            shamt_o = raw_sh[SH_W-1:0];
        end
    end

    // Purpose: exponents at or above the integer width cannot fit.
    always_comb begin
        big_o = (exp_ext >= LIMIT);
    end

endmodule

// File: rtl/fti_rshift_sticky.sv
// Module: fti_rshift_sticky
// A logarithmic right shifter that also ORs together every bit it drops.
// Each stage shifts by a power of two when its bit of the distance is set.
// A distance of DATA_W or more yields zero, with the OR of all input bits
// in sticky_o.
module fti_rshift_sticky #(
    parameter int DATA_W = 64,
    parameter int SH_W   = 7
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sticky_o
);

    logic [SH_W:0][DATA_W-1:0] stg;
    logic [SH_W:0]             stk;

    assign stg[0] = data_i;
    assign stk[0] = 1'b0;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam longint STEP = longint'(1) << k;
        localparam logic [DATA_W-1:0] LOWMASK =
            (STEP >= DATA_W) ? {DATA_W{1'b1}}
                             : (({{(DATA_W-1){1'b0}}, 1'b1} << STEP) - 1'b1);

        // Purpose: conditionally shift by 2^k and collect the dropped bits.
        always_comb begin
            if (shamt_i[k]) begin
                stg[k+1] = (STEP >= DATA_W) ? '0 : (stg[k] >> STEP);
                stk[k+1] = stk[k] | (|(stg[k] & LOWMASK));
            end else begin
                stg[k+1] = stg[k];
                stk[k+1] = stk[k];
            end
        end
    end

    assign data_o   = stg[SH_W];
    assign sticky_o = stk[SH_W];

endmodule

// File: rtl/fti_range.sv
// Module: fti_range
// Decides overflow from the shifted magnitude and applies the sign.
// A positive value may reach 2^(INT_W-1)-1. A negative value may reach
// -2^(INT_W-1). On overflow it returns the saturated value chosen by the sign.
// Assumes MANT_W > INT_W.
module fti_range #(
    parameter int MANT_W = 64,
    parameter int INT_W  = 32
) (
    input  logic              sign_i,
    input  logic              force_ovf_i,
    input  logic [MANT_W-1:0] mag_i,
    output logic [INT_W-1:0]  result_o,
    output logic              ovf_o
);

    localparam logic [INT_W:0]   HALF    = {2'b01, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W-1:0] mag_low;
    logic             high_set;
    logic [INT_W:0]   limit;
    logic             mag_ovf;

    // Purpose: split the magnitude and compute the sign-dependent limit.
    always_comb begin
        mag_low  = mag_i[INT_W-1:0];
        high_set = |mag_i[MANT_W-1:INT_W];
        limit    = HALF + {{INT_W{1'b0}}, sign_i};
        mag_ovf  = high_set || ({1'b0, mag_low} >= limit);
    end

    // Purpose: choose between saturation and the signed magnitude.
    always_comb begin
        ovf_o = force_ovf_i || mag_ovf;
        if (ovf_o) begin
            result_o = sign_i ? SAT_NEG : SAT_POS;
        end else if (sign_i) begin
            result_o = (~mag_low) + 1'b1;
        end else begin
            result_o = mag_low;
        end
    end

endmodule

// File: rtl/fti_conv.sv
// Module: fti_conv (top)
// Converts an unpacked float (sign, class, unbiased exponent, normalized
// mantissa) to a signed integer, always truncating toward zero.
// The datapath is combinational with one output register stage.
// Outputs load only when in_valid is high. Reset is synchronous, active low.
module fti_conv
    import fti_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int MANT_W = 64,
    parameter int INT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic [CLS_W-1:0]        in_class,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_result,
    output logic                    out_inexact,
    output logic                    out_invalid
);

    localparam int SH_W = $clog2(MANT_W + 1);

    logic [SH_W-1:0]   shamt;
    logic              exp_big;
    logic [MANT_W-1:0] shifted;
    logic              dropped;
    logic              is_zero;
    logic              is_num;
    logic              force_ovf;
    logic [INT_W-1:0]  range_res;
    logic              range_ovf;
    logic [INT_W-1:0]  nxt_result;
    logic              nxt_inexact;
    logic              nxt_invalid;

    fti_shamt #(
        .EXP_W (EXP_W),
        .MANT_W(MANT_W),
        .INT_W (INT_W),
        .SH_W  (SH_W)
    ) u_shamt (
        .exp_i  (in_exp),
        .shamt_o(shamt),
        .big_o  (exp_big)
    );

    fti_rshift_sticky #(
        .DATA_W(MANT_W),
        .SH_W  (SH_W)
    ) u_shift (
        .data_i  (in_mant),
        .shamt_i (shamt),
        .data_o  (shifted),
        .sticky_o(dropped)
    );

    // Purpose: decode the class and decide forced overflow.
    always_comb begin
        is_zero   = (in_class == CLS_ZERO);
        is_num    = (in_class == CLS_NUM);
        force_ovf = !is_num || exp_big;
    end

    fti_range #(
        .MANT_W(MANT_W),
        .INT_W (INT_W)
    ) u_range (
        .sign_i     (in_sign),
        .force_ovf_i(force_ovf),
        .mag_i      (shifted),
        .result_o   (range_res),
        .ovf_o      (range_ovf)
    );

    // Purpose: merge zero class and overflow into the final result and flags.
    always_comb begin
        if (is_zero) begin
            nxt_result  = '0;
            nxt_inexact = 1'b0;
            nxt_invalid = 1'b0;
        end else begin
            nxt_result  = range_res;
            nxt_invalid = range_ovf;
            nxt_inexact = dropped && !range_ovf;
        end
    end

    // Purpose: valid bit of the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Purpose: output data register, loaded only for a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_result  <= nxt_result;
            out_inexact <= nxt_inexact;
            out_invalid <= nxt_invalid;
        end
    end

endmodule

// File: rtl/fti_conv_chk.sv
// Module: fti_conv_chk
// Property checker for fti_conv, attached by the bind at the end of the file.
module fti_conv_chk
    import fti_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int MANT_W = 64,
    parameter int INT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_sign,
    input logic [CLS_W-1:0]        in_class,
    input logic signed [EXP_W-1:0] in_exp,
    input logic [MANT_W-1:0]       in_mant,
    input logic                    out_valid,
    input logic [INT_W-1:0]        out_result,
    input logic                    out_inexact,
    input logic                    out_invalid
);

    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

    logic in_special;
    logic in_big;
    logic in_negexp;

    always_comb begin
        in_special = (in_class != CLS_ZERO) && (in_class != CLS_NUM);
        in_big     = (in_class == CLS_NUM) && (in_exp >= $signed(INT_W));
        in_negexp  = (in_class == CLS_NUM) && (in_exp < 0);
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_inexact) && $stable(out_invalid)); // R2
    AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_ZERO) |=> (out_result == '0 && !out_inexact && !out_invalid)); // R3
    AST_SPECIAL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_special) |=>
            (out_invalid && !out_inexact && out_result == ($past(in_sign) ? SAT_NEG : SAT_POS))); // R4
    AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_big) |=>
            (out_invalid && !out_inexact && out_result == ($past(in_sign) ? SAT_NEG : SAT_POS))); // R5
    AST_NEG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_negexp) |=>
            (out_result == '0 && !out_invalid && out_inexact == (|$past(in_mant)))); // R8
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_inexact && out_invalid)); // R12

endmodule

bind fti_conv fti_conv_chk #(
    .EXP_W (EXP_W),
    .MANT_W(MANT_W),
    .INT_W (INT_W)
) u_fti_conv_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sign    (in_sign),
    .in_class   (in_class),
    .in_exp     (in_exp),
    .in_mant    (in_mant),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_inexact(out_inexact),
    .out_invalid(out_invalid)
);

// File: tb/fti_conv_bench.sv
// Bench for fti_conv: behavioural reference, compared on every clock.
module fti_conv_bench;

    localparam int EXP_W  = 16;
    localparam int MANT_W = 64;
    localparam int INT_W  = 32;
    localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_sign = 1'b0;
    logic [2:0]              in_class = 3'd0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [MANT_W-1:0]       in_mant = '0;
    logic                    out_valid;
    logic [INT_W-1:0]        out_result;
    logic                    out_inexact;
    logic                    out_invalid;

    int tests = 0;
    int fails = 0;

    logic        e_valid = 1'b0;
    logic [31:0] e_result = '0;
    logic        e_nx = 1'b0;
    logic        e_nv = 1'b0;

    always #4 clk = ~clk;

    fti_conv #(.EXP_W(EXP_W), .MANT_W(MANT_W), .INT_W(INT_W)) u_fti_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
        .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    // Arithmetic reference: truncate, then compare the magnitude with the signed range.
    function automatic void ref_conv(input logic s, input logic [2:0] c, input int e,
                                     input logic [63:0] m, output logic [31:0] r,
                                     output logic nx, output logic nv);
        logic [63:0] mag;
        logic        ovf;
        int          sh;
        mag = '0;
        nx  = 1'b0;
        ovf = 1'b0;
        if (c == 3'd0) begin
            r  = '0;
            nv = 1'b0;
            return;
        end
        if (c != 3'd1) ovf = 1'b1;
        else if (e >= 32) ovf = 1'b1;
        else begin
            if (e < 0) begin
                mag = '0;
                nx  = (m != 0);
            end else begin
                sh  = 63 - e;
                mag = m >> sh;
                nx  = ((m << (64 - sh)) != 0);
            end
            if (mag >= 64'h8000_0000 + {63'd0, s}) ovf = 1'b1;
        end
        if (ovf) begin
            r  = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
            nx = 1'b0;
            nv = 1'b1;
        end else begin
            r  = s ? (32'd0 - mag[31:0]) : mag[31:0];
            nv = 1'b0;
        end
    endfunction

    task automatic compare(input string tag);
        tests++;
        if (out_valid !== e_valid || out_result !== e_result ||
            out_inexact !== e_nx || out_invalid !== e_nv) begin
            fails++;
            $display("FAIL %s: got v=%0b r=%08h nx=%0b nv=%0b, expected v=%0b r=%08h nx=%0b nv=%0b",
                     tag, out_valid, out_result, out_inexact, out_invalid,
                     e_valid, e_result, e_nx, e_nv);
        end
        tests++;
        if (out_inexact && out_invalid) begin
            fails++;
            $display("FAIL R12: got nx=1 nv=1, expected not both");
        end
    endtask

    // Drive one cycle, update the reference at the edge, compare at the falling edge.
    task automatic apply(input logic v, input logic s, input logic [2:0] c,
                         input int e, input logic [63:0] m, input string tag);
        logic [31:0] r;
        logic        nx;
        logic        nv;
        in_valid = v;
        in_sign  = s;
        in_class = c;
        in_exp   = EXP_W'(e);
        in_mant  = m;
        @(posedge clk);
        #1;
        ref_conv(s, c, e, m, r, nx, nv);
        e_valid = v;
        if (v) begin
            e_result = r;
            e_nx     = nx;
            e_nv     = nv;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;

        apply(1, 0, 3'd0, 5, TOP | 64'h55, "R3 zero positive");
        apply(1, 1, 3'd0, 40, TOP, "R3 zero negative");
        apply(1, 0, 3'd2, 3, TOP, "R4 inf positive");
        apply(1, 1, 3'd2, 3, TOP, "R4 inf negative");
        apply(1, 0, 3'd3, 0, TOP | 64'h1, "R4 quiet NaN");
        apply(1, 1, 3'd4, 0, TOP, "R4 signalling NaN");
        apply(1, 0, 3'd7, 0, TOP, "R4 unused code");
        apply(1, 0, 3'd1, 0, TOP, "R6 one");
        apply(1, 0, 3'd1, 1, TOP | (TOP >> 1), "R6 three exact");
        apply(1, 1, 3'd1, 1, TOP | (TOP >> 2), "R11 R7 minus 2.5");
        apply(1, 0, 3'd1, 30, 64'hFFFF_FFFF_FFFF_FFFF, "R7 max positive inexact");
        apply(1, 0, 3'd1, 32, TOP, "R5 exp 32");
        apply(1, 1, 3'd1, 1000, TOP, "R5 huge negative");
        apply(1, 0, 3'd1, -1, TOP, "R8 half");
        apply(1, 1, 3'd1, -32768, TOP, "R8 most negative exp");
        apply(1, 0, 3'd1, 31, TOP, "R9 positive 2^31");
        apply(1, 1, 3'd1, 31, TOP, "R9 negative 2^31");
        apply(1, 1, 3'd1, 31, TOP | 64'h1, "R9 negative 2^31 inexact");
        apply(1, 1, 3'd1, 31, TOP | 64'h1_0000_0000, "R9 negative 2^31+1");
        apply(1, 0, 3'd1, 31, TOP | 64'h1, "R10 overflow drops inexact");
        apply(0, 1, 3'd1, 2, TOP, "R2 hold");
        apply(0, 0, 3'd2, 0, TOP, "R2 hold special");
        apply(1, 0, 3'd1, 4, TOP, "R2 resume");

        for (int i = 0; i < 400; i++) begin
            int          pick;
            logic [2:0]  c;
            logic [63:0] m;
            pick = $urandom_range(0, 9);
            c = (pick == 0) ? 3'd0 : (pick == 1) ? 3'd2 : (pick == 2) ? 3'd4 : 3'd1;
            m = {$urandom, $urandom} | TOP;
            apply(($urandom_range(0, 9) != 0), $urandom_range(0, 1), c,
                  $urandom_range(0, 40) - 5, m, "R6 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule